// File: doc/BRIEF.md
# Cascaded Pulse Accumulator

This block counts pulses on one input pin with a 16-bit counter built from two 8-bit halves. The upper half carries from the lower one, so the pair acts as a single 16-bit count. In event mode the counter advances on each selected edge of the pin. In gated mode the pin acts as a gate: the counter advances on each prescaled clock enable while the gate is at its active level.

Two sticky flags record an overflow and an input edge. Software clears them by writing ones. An optional mode clears them on any access to the count instead. A max-count mode pins the upper half at 0xFF. An interrupt line combines each flag with its own enable.

Software uses a small register bus with three locations: control at address 0, flags at address 1 and count at address 2. Writes to the count honour byte enables. A read returns the whole count word.

Top module: `pulse_accum16`

## Requirements
- R1: After reset the control register, the flags, the count and `irq` are all zero.
- R2: In event mode (control bit1 = 0, control bit0 = 1) the count goes up by one on each edge selected by control bit2 (1 = rising, 0 = falling). The other edge is ignored. The pin passes through two synchronizer flops, so the new count can be read after the third rising clock edge that follows a pin change.
- R3: While control bit0 is 0, pin activity leaves both the count and the flags unchanged.
- R4: The two halves chain: a carry out of the low byte increments the high byte. A step from 0xFFFF to 0x0000 sets the overflow flag (flag bit1). A carry from the low byte into a high byte below 0xFF does not set it.
- R5: With max-count mode on (control bit3 = 1), the high byte holds at 0xFF and the low byte keeps counting. Any increment that happens while the high byte is already 0xFF sets the overflow flag.
- R6: In event mode each counted edge sets the edge flag (flag bit0).
- R7: In gated mode (control bit1 = 1) the count goes up by one for each `tick_en` cycle while the synchronized pin equals control bit2. The edge flag sets on the trailing edge of the gate and not on its leading edge.
- R8: Writing a one to a flag bit at address 1 clears that flag and leaves the other flag unchanged. A set event in the same cycle wins.
- R9: With fast-clear on (control bit4 = 1), any read or write strobe to address 2 clears both flags. With fast-clear off, a read of the count leaves the flags unchanged.
- R10: A count write with `bus_be` = 2'b11 loads both bytes in one cycle. `bus_be[1]` selects the high byte and `bus_be[0]` the low byte. `bus_rdata` shows the full count, combinationally from the address.
- R11: `irq` is high when the overflow flag is set and control bit6 is 1, or when the edge flag is set and control bit5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 flags, 2 count |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used by fast-clear) |
| bus_be | input | 2 | Byte enables for count writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pa_pin | input | 1 | Asynchronous pulse or gate input |
| tick_en | input | 1 | Prescaled clock enable for gated mode |
| irq | output | 1 | Interrupt request |

## Verification
- Timing of pin stimulus: a pin change reaches the count and the edge flag after three rising clock edges, because of the two synchronizer flops and the history flop. The bench therefore waits three cycles after each pin change before it reads anything.
- Timing of bus and tick stimulus: bus writes and `tick_en` pulses act at the very next rising edge. Read data and `irq` are combinational, so the bench samples them at the falling edge after that.
- Expected values: the bench works out each expected count by adding the number of stimulus pulses to the value it wrote. It sweeps both edge polarities over several pulse counts, and it covers the wrap and saturation boundaries near 0xFFFF.

// File: rtl/pulse_accum16.sv
module pulse_accum16 #(
  parameter int SEG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_be,
  input  logic [2*SEG_W-1:0] bus_wdata,
  output logic [2*SEG_W-1:0] bus_rdata,
  input  logic               pa_pin,
  input  logic               tick_en,
  output logic               irq
);
  localparam int CNT_W = 2 * SEG_W;
  localparam logic [SEG_W-1:0] SEG_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [6:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic             ovf_f, edg_f;
  logic [2:0]       sync;

  wire en     = ctrl[0];
  wire gated  = ctrl[1];
  wire pol    = ctrl[2];
  wire maxm   = ctrl[3];
  wire fclr   = ctrl[4];
  wire edg_ie = ctrl[5];
  wire ovf_ie = ctrl[6];

  wire rise     = sync[1] & ~sync[2];
  wire fall     = ~sync[1] & sync[2];
  wire act_edge = pol ? rise : fall;
  wire trail    = pol ? fall : rise;
  wire gate_on  = (sync[1] == pol);

  wire inc      = en & (gated ? (tick_en & gate_on) : act_edge);
  wire edge_evt = en & (gated ? trail : act_edge);

  wire [SEG_W-1:0] hi = cnt[CNT_W-1:SEG_W];
  wire [SEG_W-1:0] lo = cnt[SEG_W-1:0];
  wire hi_full  = (hi == SEG_MAX);
  wire ovf_evt  = inc & hi_full & (maxm | (lo == SEG_MAX));

  wire sel_flg  = (bus_addr == 2'd1);
  wire sel_cnt  = (bus_addr == 2'd2);
  wire wr_cnt   = bus_wr & sel_cnt;
  wire fast_hit = fclr & (bus_wr | bus_rd) & sel_cnt;
  wire clr_ovf  = (bus_wr & sel_flg & bus_wdata[1]) | fast_hit;
  wire clr_edg  = (bus_wr & sel_flg & bus_wdata[0]) | fast_hit;

  logic [SEG_W-1:0] lo_p1;
  logic [CNT_W-1:0] cnt_inc, cnt_nxt;

  always_comb begin
    lo_p1   = lo + 1'b1;
    cnt_inc = cnt;
    if (inc) begin
      if (maxm && hi_full) cnt_inc = {SEG_MAX, lo_p1};
      else                 cnt_inc = cnt + 1'b1;
    end
    cnt_nxt = cnt_inc;
    if (wr_cnt) begin
      if (bus_be[1]) cnt_nxt[CNT_W-1:SEG_W] = bus_wdata[CNT_W-1:SEG_W];
      if (bus_be[0]) cnt_nxt[SEG_W-1:0]     = bus_wdata[SEG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cnt   <= '0;
      ovf_f <= 1'b0;
      edg_f <= 1'b0;
      sync  <= '0;
    end else begin
      sync  <= {sync[1:0], pa_pin};
      cnt   <= cnt_nxt;
      ovf_f <= (ovf_f & ~clr_ovf) | ovf_evt;
      edg_f <= (edg_f & ~clr_edg) | edge_evt;
      if (bus_wr && bus_addr == 2'd0) ctrl <= bus_wdata[6:0];
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = CNT_W'(ctrl);
      2'd1:    bus_rdata = CNT_W'({ovf_f, edg_f});
      2'd2:    bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (ovf_f & ovf_ie) | (edg_f & edg_ie);

  // R4
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !maxm && cnt == CNT_MAX && !wr_cnt |=> ovf_f && cnt == '0);
  // R5
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && maxm && hi_full && !wr_cnt |=> cnt[CNT_W-1:SEG_W] == SEG_MAX && ovf_f);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_cnt |=> $stable(cnt));
  // R6
  edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> edg_f);
  // R8
  w1c_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_flg && bus_wdata[1] && !ovf_evt |=> !ovf_f);
endmodule

// File: tb/tb_pulse_accum16.sv
module tb_pulse_accum16;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0, bus_be = 0;
  logic bus_wr = 0, bus_rd = 0, pa_pin = 0, tick_en = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pulse_accum16 dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_pin(pa_pin), .tick_en(tick_en), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_strobe(input logic [1:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); pa_pin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 flags", d, 0);
    rd(2, d); check("R1 count", d, 0);
    check("R1 irq", {15'b0, irq}, 0);

    // R2 / R6: sweep polarity and pulse count
    for (int p = 0; p < 2; p++) begin
      for (int n = 1; n <= 6; n++) begin
        logic idle;
        idle = (p == 0);
        wr(0, 16'h0000, 2'b11);
        pin_set(idle);
        wr(0, 16'h0001 | (16'(p) << 2), 2'b11);
        wr(2, 16'h0000, 2'b11);
        wr(1, 16'h0003, 2'b11);
        for (int k = 0; k < n; k++) begin
          pin_set(~idle); pin_set(idle);
        end
        rd(2, d); check("R2 count", d, 16'(n));
        rd(1, d); check("R6 edge flag", d & 16'h1, 16'h1);
        pin_set(~idle);
        rd(2, d); check("R2 active edge", d, 16'(n + 1));
        pin_set(idle);
        rd(2, d); check("R2 other edge ignored", d, 16'(n + 1));
      end
    end

    // R3
    wr(0, 16'h0000, 2'b11);
    wr(2, 16'h0042, 2'b11);
    wr(1, 16'h0003, 2'b11);
    for (int k = 0; k < 3; k++) begin pin_set(0); pin_set(1); end
    pin_set(0);
    rd(2, d); check("R3 count held", d, 16'h0042);
    rd(1, d); check("R3 flags held", d, 0);

    // R10
    wr(2, 16'h12FE, 2'b11); rd(2, d); check("R10 word write", d, 16'h12FE);
    wr(2, 16'hAB00, 2'b10); rd(2, d); check("R10 high byte", d, 16'hABFE);
    wr(2, 16'h0033, 2'b01); rd(2, d); check("R10 low byte", d, 16'hAB33);

    // R4
    wr(0, 16'h0005, 2'b11);
    wr(2, 16'h00FF, 2'b11); wr(1, 16'h0003, 2'b11);
    pin_set(1); pin_set(0);
    rd(2, d); check("R4 byte carry", d, 16'h0100);
    rd(1, d); check("R4 no ovf on carry", d & 16'h2, 0);
    wr(2, 16'hFFFE, 2'b11);
    pin_set(1); pin_set(0);
    rd(2, d); check("R4 to FFFF", d, 16'hFFFF);
    rd(1, d); check("R4 no ovf yet", d & 16'h2, 0);
    pin_set(1); pin_set(0);
    rd(2, d); check("R4 wrap", d, 16'h0000);
    rd(1, d); check("R4 ovf set", d, 16'h0003);

    // R8
    wr(1, 16'h0002, 2'b11); rd(1, d); check("R8 clear ovf only", d, 16'h0001);
    wr(1, 16'h0001, 2'b11); rd(1, d); check("R8 clear edge", d, 16'h0000);

    // R5
    wr(0, 16'h000D, 2'b11);
    wr(2, 16'hFEFF, 2'b11); wr(1, 16'h0003, 2'b11);
    pin_set(1); pin_set(0);
    rd(2, d); check("R5 enter FF", d, 16'hFF00);
    rd(1, d); check("R5 no ovf below FF", d & 16'h2, 0);
    pin_set(1); pin_set(0);
    rd(2, d); check("R5 low counts", d, 16'hFF01);
    rd(1, d); check("R5 ovf at FF", d & 16'h2, 16'h2);
    wr(2, 16'hFFFF, 2'b11); wr(1, 16'h0003, 2'b11);
    pin_set(1); pin_set(0);
    rd(2, d); check("R5 high holds", d, 16'hFF00);
    rd(1, d); check("R5 ovf again", d & 16'h2, 16'h2);

    // R7 active-high gate
    wr(0, 16'h0000, 2'b11);
    pin_set(0);
    wr(0, 16'h0007, 2'b11);
    wr(2, 16'h0000, 2'b11); wr(1, 16'h0003, 2'b11);
    ticks(4);
    rd(2, d); check("R7 gate closed", d, 0);
    pin_set(1);
    rd(1, d); check("R7 no flag on leading", d, 0);
    ticks(5);
    rd(2, d); check("R7 gated count", d, 16'd5);
    pin_set(0);
    rd(1, d); check("R7 trailing flag", d, 16'h0001);
    rd(2, d); check("R7 count after gate", d, 16'd5);
    // R7 active-low gate
    wr(0, 16'h0003, 2'b11);
    wr(2, 16'h0000, 2'b11); wr(1, 16'h0003, 2'b11);
    ticks(3);
    rd(2, d); check("R7 low gate count", d, 16'd3);
    pin_set(1);
    rd(1, d); check("R7 low gate trailing", d, 16'h0001);
    ticks(2);
    rd(2, d); check("R7 low gate closed", d, 16'd3);

    // R9
    wr(0, 16'h0013, 2'b11);
    rd_strobe(2);
    rd(1, d); check("R9 fast clear on read", d, 0);
    wr(0, 16'h0003, 2'b11);
    pin_set(0); pin_set(1);
    rd_strobe(2);
    rd(1, d); check("R9 no clear when off", d, 16'h0001);
    wr(0, 16'h0013, 2'b11);
    wr(2, 16'h0000, 2'b11);
    rd(1, d); check("R9 fast clear on write", d, 0);

    // R11
    wr(0, 16'h0023, 2'b11);
    pin_set(0); pin_set(1);
    check("R11 irq edge", {15'b0, irq}, 1);
    wr(0, 16'h0003, 2'b11);
    check("R11 irq masked", {15'b0, irq}, 0);
    wr(2, 16'hFFFF, 2'b11);
    pin_set(0);
    ticks(1);
    pin_set(1);
    wr(1, 16'h0001, 2'b11);
    rd(1, d); check("R11 ovf only", d, 16'h0002);
    wr(0, 16'h0043, 2'b11);
    check("R11 irq ovf", {15'b0, irq}, 1);
    wr(0, 16'h0023, 2'b11);
    check("R11 irq edge enable only", {15'b0, irq}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule